// File: doc/BRIEF.md
# Multi-Cycle 32-bit RISC Core

This block is a small non-pipelined 32-bit processor core built as a clocked state machine. It fetches one word-wide instruction at a time from an external memory and executes it over one or two cycles. It then fetches the next instruction. The core keeps a 32-entry register file whose entry 0 always reads as zero, a program counter and an instruction register. Memory is addressed in words, so the program counter steps by one per instruction.

All core registers update on the rising clock edge. The memory and any memory-mapped peripheral attached to the bus are expected to act on the falling edge between two rising edges. They sample the strobes and address that the core set up on the preceding rising edge. The bidirectional data bus is split into a write-data output, an output enable and a read-data input, so a board-level wrapper can build the tri-state pad. The read strobe, the write strobe and the halt flag are active low.

Reset is synchronous and active high. It clears the program counter and every register, and execution starts at address 0. A halt instruction parks the core until the next reset.

Top module: `rcpu_core`

## Requirements
- R1: While reset is high, and in the cycle after it, both strobes and the halt flag are high and the write-data enable is low. After reset every register reads zero and the first fetch is from address 0.
- R2: A fetch drives the PC onto the address output and holds the read strobe low for exactly one cycle. The word on the read-data input is captured at the next rising edge. A register or immediate instruction takes 3 cycles from one fetch to the next.
- R3: Register 0 reads as zero, and every write aimed at it is dropped.
- R4: Register instructions use opcode in bits 31:26, source A in 25:21, source B in 20:16 and destination in 15:11. The operations are MOV 010001 (B-field register gets A), ADD 010010 (dest = A+B) and SUB 010011 (dest = A−B, modulo 2^32).
- R5: Immediate instructions put the target register in bits 20:16 and a 16-bit immediate, zero-extended, in bits 15:0. The operations are ADDI 001000 (add), SUBI 001001 (subtract) and ANDI 001100 (bitwise AND).
- R6: BEQ 000100 and BNE 000101 compare the registers in fields 25:21 and 20:16. When the test holds they load the PC with the immediate as an absolute address; otherwise the PC becomes PC+1.
- R7: JUMP 000010 loads the PC with bits 25:0 zero-extended.
- R8: LW 100011 spends two execute cycles. In the first it puts A+imm on the address output with the read strobe low. In the second it writes the read word into the B-field register. It takes 4 cycles from fetch to fetch.
- R9: SW 101011 puts A+imm on the address output and the B-field register on write data. The write strobe and the write-data enable are asserted together for exactly one cycle.
- R10: HALT 111111 drives the halt flag low and keeps it low. After that no strobe is asserted until reset.
- R11: Any opcode not listed above executes as a no-operation and advances the PC by one in 3 cycles.
- R12: The read and write strobes are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Word address for fetch, load or store |
| mem_wdata | output | 32 | Store data |
| mem_wdata_oe | output | 1 | High while store data should be driven onto the shared bus |
| mem_rdata | input | 32 | Read data returned by memory or peripheral |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| halt_n | output | 1 | Low once a halt instruction has executed |

## Verification
The case that matters most is a load whose register write-back lands on the same rising edge that commits the new PC. That edge also moves the core back to fetch, so the very next instruction reads the register that was just written. The bench provokes it with a load followed directly by a store of the same register, first from a memory word and then from the I/O address. It judges the result by the value that arrives at the store port. A second same-edge case is a register write and a taken branch whose comparison reads that register in the next instruction. This case is covered by the branch programs, which set up both operands immediately before the branch.

// File: rtl/rcpu_pkg.sv
package rcpu_pkg;

  localparam int XLEN_D = 32;
  localparam int OPC_W  = 6;
  localparam int RIDX_W = 5;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;

  localparam logic [OPC_W-1:0] OPC_NOP  = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'b000101;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_SUBI = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'b001100;
  localparam logic [OPC_W-1:0] OPC_MOV  = 6'b010001;
  localparam logic [OPC_W-1:0] OPC_ADD  = 6'b010010;
  localparam logic [OPC_W-1:0] OPC_SUB  = 6'b010011;
  localparam logic [OPC_W-1:0] OPC_LW   = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_SW   = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_HLT  = 6'b111111;

  typedef enum logic [2:0] {
    CLS_NOP, CLS_ALU, CLS_JUMP, CLS_BRANCH, CLS_LOAD, CLS_STORE, CLS_HALT
  } cls_e;

  typedef enum logic [1:0] {
    ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND
  } alu_e;

  typedef enum logic [2:0] {
    ST_RESET, ST_FETCH0, ST_FETCH1, ST_EXEC, ST_HALT
  } state_e;

  typedef struct packed {
    cls_e              cls;
    alu_e              alu;
    logic              use_imm;
    logic              br_ne;
    logic [RIDX_W-1:0] rs;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] wr_idx;
    logic [IMM_W-1:0]  imm;
    logic [TGT_W-1:0]  tgt;
  } dec_t;

endpackage

// File: rtl/rcpu_decode.sv
module rcpu_decode
  import rcpu_pkg::*;
#(
  parameter int XLEN = XLEN_D
) (
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);

  logic [OPC_W-1:0]  opc;
  logic [RIDX_W-1:0] f_rd;

  assign opc  = instr[31:26];
  assign f_rd = instr[15:11];

  always_comb begin
    dec         = '0;
    dec.cls     = CLS_NOP;
    dec.alu     = ALU_PASS;
    dec.rs      = instr[25:21];
    dec.rt      = instr[20:16];
    dec.imm     = instr[IMM_W-1:0];
    dec.tgt     = instr[TGT_W-1:0];
    dec.wr_idx  = '0;
    dec.use_imm = 1'b0;
    dec.br_ne   = 1'b0;
    case (opc)
      OPC_MOV:  begin dec.cls = CLS_ALU; dec.alu = ALU_PASS; dec.wr_idx = instr[20:16]; end
      OPC_ADD:  begin dec.cls = CLS_ALU; dec.alu = ALU_ADD;  dec.wr_idx = f_rd; end
      OPC_SUB:  begin dec.cls = CLS_ALU; dec.alu = ALU_SUB;  dec.wr_idx = f_rd; end
      OPC_ADDI: begin dec.cls = CLS_ALU; dec.alu = ALU_ADD;  dec.use_imm = 1'b1; dec.wr_idx = instr[20:16]; end
      OPC_SUBI: begin dec.cls = CLS_ALU; dec.alu = ALU_SUB;  dec.use_imm = 1'b1; dec.wr_idx = instr[20:16]; end
      OPC_ANDI: begin dec.cls = CLS_ALU; dec.alu = ALU_AND;  dec.use_imm = 1'b1; dec.wr_idx = instr[20:16]; end
      OPC_BEQ:  begin dec.cls = CLS_BRANCH; end
      OPC_BNE:  begin dec.cls = CLS_BRANCH; dec.br_ne = 1'b1; end
      OPC_JMP:  begin dec.cls = CLS_JUMP; end
      OPC_LW:   begin dec.cls = CLS_LOAD;  dec.wr_idx = instr[20:16]; end
      OPC_SW:   begin dec.cls = CLS_STORE; end
      OPC_HLT:  begin dec.cls = CLS_HALT; end
      default:  begin dec.cls = CLS_NOP; end
    endcase
  end

endmodule

// File: rtl/rcpu_exec.sv
module rcpu_exec
  import rcpu_pkg::*;
#(
  parameter int XLEN = XLEN_D
) (
  input  cls_e             cls,
  input  alu_e             alu,
  input  logic             use_imm,
  input  logic             br_ne,
  input  logic [IMM_W-1:0] imm,
  input  logic [TGT_W-1:0] tgt,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  input  logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  alu_res,
  output logic [XLEN-1:0]  eff_addr,
  output logic [XLEN-1:0]  next_pc
);

  localparam int IMM_PAD = XLEN - IMM_W;
  localparam int TGT_PAD = XLEN - TGT_W;

  logic [XLEN-1:0] imm_z;
  logic [XLEN-1:0] opb;
  logic [XLEN-1:0] pc_inc;
  logic            taken;

  assign imm_z    = {{IMM_PAD{1'b0}}, imm};
  assign opb      = use_imm ? imm_z : rt_val;
  assign eff_addr = rs_val + imm_z;
  assign pc_inc   = pc + {{(XLEN-1){1'b0}}, 1'b1};
  assign taken    = (rs_val == rt_val) ^ br_ne;

  always_comb begin
    case (alu)
      ALU_ADD: alu_res = rs_val + opb;
      ALU_SUB: alu_res = rs_val - opb;
      ALU_AND: alu_res = rs_val & opb;
      default: alu_res = rs_val;
    endcase
  end

  always_comb begin
    case (cls)
      CLS_JUMP:   next_pc = {{TGT_PAD{1'b0}}, tgt};
      CLS_BRANCH: next_pc = taken ? imm_z : pc_inc;
      default:    next_pc = pc_inc;
    endcase
  end

endmodule

// File: rtl/rcpu_regfile.sv
module rcpu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [XLEN-1:0]         wdata,
  input  logic [$clog2(NREG)-1:0] raddr_a,
  input  logic [$clog2(NREG)-1:0] raddr_b,
  output logic [XLEN-1:0]         rdata_a,
  output logic [XLEN-1:0]         rdata_b
);

  localparam int IDX_W = $clog2(NREG);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == IDX_W'(0)) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == IDX_W'(0)) ? '0 : regs[raddr_b];

endmodule

// File: rtl/rcpu_core.sv
module rcpu_core
  import rcpu_pkg::*;
#(
  parameter int XLEN = XLEN_D,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_wdata_oe,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_rd_n,
  output logic            mem_wr_n,
  output logic            halt_n
);

  localparam int IDX_W = $clog2(NREG);

  state_e          state;
  logic            sub;
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] ir;
  dec_t            dec;

  logic [XLEN-1:0] rs_val, rt_val, alu_res, eff_addr, next_pc;
  logic            rf_we, rf_clr;
  logic [XLEN-1:0] rf_wdata;

  rcpu_decode #(.XLEN(XLEN)) u_dec (
    .instr (ir),
    .dec   (dec)
  );

  rcpu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .clr     (rf_clr),
    .we      (rf_we),
    .waddr   (IDX_W'(dec.wr_idx)),
    .wdata   (rf_wdata),
    .raddr_a (IDX_W'(dec.rs)),
    .raddr_b (IDX_W'(dec.rt)),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  rcpu_exec #(.XLEN(XLEN)) u_exe (
    .cls      (dec.cls),
    .alu      (dec.alu),
    .use_imm  (dec.use_imm),
    .br_ne    (dec.br_ne),
    .imm      (dec.imm),
    .tgt      (dec.tgt),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .pc       (pc),
    .alu_res  (alu_res),
    .eff_addr (eff_addr),
    .next_pc  (next_pc)
  );

  assign rf_clr = rst || (state == ST_RESET);

  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = alu_res;
    if (state == ST_EXEC) begin
      if (dec.cls == CLS_ALU) begin
        rf_we = 1'b1;
      end else if (dec.cls == CLS_LOAD && sub) begin
        rf_we    = 1'b1;
        rf_wdata = mem_rdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_RESET;
      sub          <= 1'b0;
      pc           <= '0;
      ir           <= '0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_wdata_oe <= 1'b0;
      mem_rd_n     <= 1'b1;
      mem_wr_n     <= 1'b1;
      halt_n       <= 1'b1;
    end else begin
      case (state)
        ST_RESET: begin
          pc           <= '0;
          mem_rd_n     <= 1'b1;
          mem_wr_n     <= 1'b1;
          mem_wdata_oe <= 1'b0;
          halt_n       <= 1'b1;
          state        <= ST_FETCH0;
        end
        ST_FETCH0: begin
          mem_addr     <= pc;
          mem_wdata_oe <= 1'b0;
          mem_rd_n     <= 1'b0;
          state        <= ST_FETCH1;
        end
        ST_FETCH1: begin
          ir       <= mem_rdata;
          mem_rd_n <= 1'b1;
          sub      <= 1'b0;
          state    <= ST_EXEC;
        end
        ST_EXEC: begin
          case (dec.cls)
            CLS_LOAD: begin
              if (!sub) begin
                mem_addr <= eff_addr;
                mem_rd_n <= 1'b0;
                sub      <= 1'b1;
              end else begin
                mem_rd_n <= 1'b1;
                pc       <= next_pc;
                state    <= ST_FETCH0;
              end
            end
            CLS_STORE: begin
              if (!sub) begin
                mem_addr     <= eff_addr;
                mem_wdata    <= rt_val;
                mem_wdata_oe <= 1'b1;
                mem_wr_n     <= 1'b0;
                sub          <= 1'b1;
              end else begin
                mem_wdata_oe <= 1'b0;
                mem_wr_n     <= 1'b1;
                pc           <= next_pc;
                state        <= ST_FETCH0;
              end
            end
            CLS_HALT: begin
              halt_n <= 1'b0;
              state  <= ST_HALT;
            end
            default: begin
              pc    <= next_pc;
              state <= ST_FETCH0;
            end
          endcase
        end
        ST_HALT: begin
          halt_n <= 1'b0;
        end
        default: state <= ST_RESET;
      endcase
    end
  end

endmodule

// File: rtl/rcpu_core_chk.sv
module rcpu_core_chk (
  input logic clk,
  input logic rst,
  input logic rd_n,
  input logic wr_n,
  input logic oe,
  input logic halt_n
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (rd_n && wr_n && halt_n && !oe));

  p_rd_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_n |=> rd_n);

  p_wr_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> wr_n);

  p_oe_with_wr_r9: assert property (@(posedge clk) disable iff (rst)
    oe == !wr_n);

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !halt_n |=> !halt_n);

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !halt_n |-> (rd_n && wr_n));

  p_one_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    rd_n || wr_n);

endmodule

bind rcpu_core rcpu_core_chk chk_i (
  .clk    (clk),
  .rst    (rst),
  .rd_n   (mem_rd_n),
  .wr_n   (mem_wr_n),
  .oe     (mem_wdata_oe),
  .halt_n (halt_n)
);

// File: tb/rcpu_core_tb_top.sv
module rcpu_core_tb_top;

  localparam logic [5:0] O_NOP = 6'b000000, O_JMP = 6'b000010, O_BEQ = 6'b000100,
                         O_BNE = 6'b000101, O_ADDI = 6'b001000, O_SUBI = 6'b001001,
                         O_ANDI = 6'b001100, O_MOV = 6'b010001, O_ADD = 6'b010010,
                         O_SUB = 6'b010011, O_LW = 6'b100011, O_SW = 6'b101011,
                         O_HLT = 6'b111111;
  localparam logic [31:0] IO_ADDR = 32'h0000_8000;
  localparam logic [31:0] IO_IN   = 32'h1234_A5A5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_wdata_oe, mem_rd_n, mem_wr_n, halt_n;

  always #10 clk = ~clk;

  rcpu_core dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .halt_n(halt_n)
  );

  logic [31:0] mem [0:63];
  logic [31:0] st_log [0:7];
  int          st_cnt = 0;
  int          rd_cnt = 0;
  int          cyc = 0;
  int          fetch_t [0:63];
  int          dual_cnt = 0;
  int          oe_bad = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  initial mem_rdata = '0;

  // memory and I/O model acting on the falling edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!mem_rd_n && !mem_wr_n) dual_cnt <= dual_cnt + 1;
    if (mem_wdata_oe != !mem_wr_n) oe_bad <= oe_bad + 1;
    if (!mem_rd_n) begin
      rd_cnt <= rd_cnt + 1;
      if (mem_addr < 64) fetch_t[mem_addr[5:0]] <= cyc;
      mem_rdata <= (mem_addr == IO_ADDR) ? IO_IN : mem[mem_addr[5:0]];
    end
    if (!mem_wr_n) begin
      if (mem_addr == IO_ADDR) begin
        st_log[st_cnt[2:0]] <= mem_wdata;
        st_cnt <= st_cnt + 1;
      end else begin
        mem[mem_addr[5:0]] <= mem_wdata;
      end
    end
  end

  function automatic logic [31:0] enc_r(logic [5:0] op, logic [4:0] a, logic [4:0] b, logic [4:0] d);
    return {op, a, b, d, 11'd0};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] a, logic [4:0] b, logic [15:0] imm);
    return {op, a, b, imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] t);
    return {op, t};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    for (int i = 0; i < 64; i++) fetch_t[i] = -1;
  endtask

  task automatic run_prog(input string req);
    bit halted;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    st_cnt = 0;
    rst = 1'b0;
    halted = 0;
    for (int i = 0; i < 2000 && !halted; i++) begin
      @(negedge clk);
      if (!halt_n) halted = 1;
    end
    if (!halted) begin
      n_chk++;
      n_fail++;
      $display("FAIL %s actual=running expected=halted", req);
    end
  endtask

  typedef struct packed {
    logic [1:0]  kind;   // 0 register op, 1 immediate op, 2 move
    logic [5:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, O_ADD,  16'h0005, 16'h0007, 32'h0000_000C},
    '{2'd0, O_ADD,  16'hFFFF, 16'hFFFF, 32'h0001_FFFE},
    '{2'd0, O_SUB,  16'h0003, 16'h0005, 32'hFFFF_FFFE},
    '{2'd0, O_SUB,  16'h1000, 16'h0001, 32'h0000_0FFF},
    '{2'd2, O_MOV,  16'hBEEF, 16'h0000, 32'h0000_BEEF},
    '{2'd1, O_ADDI, 16'h0010, 16'hFFFF, 32'h0001_000F},
    '{2'd1, O_SUBI, 16'h0000, 16'h8000, 32'hFFFF_8000},
    '{2'd1, O_ANDI, 16'hF0F0, 16'h0FF0, 32'h0000_00F0}
  };

  task automatic branch_case(input logic [5:0] op, input logic [15:0] bval, input logic [31:0] exp);
    clear_mem();
    mem[0] = enc_i(O_ADDI, 0, 1, 16'd1);
    mem[1] = enc_i(O_ADDI, 0, 2, bval);
    mem[2] = enc_i(op, 1, 2, 16'd6);
    mem[3] = enc_i(O_SW, 0, 0, 16'h8000);
    mem[4] = enc_j(O_HLT, 0);
    mem[6] = enc_i(O_ADDI, 0, 3, 16'h0066);
    mem[7] = enc_i(O_SW, 0, 3, 16'h8000);
    mem[8] = enc_j(O_HLT, 0);
    run_prog("R6");
    check("R6 branch result", st_log[0], exp);
    check("R6 single store", st_cnt, 1);
  endtask

  initial begin
    // R1: reset state of the outputs
    clear_mem();
    repeat (2) @(negedge clk);
    check("R1 rd_n in reset", {31'd0, mem_rd_n}, 1);
    check("R1 wr_n in reset", {31'd0, mem_wr_n}, 1);
    check("R1 halt_n in reset", {31'd0, halt_n}, 1);
    check("R1 oe in reset", {31'd0, mem_wdata_oe}, 0);

    // table-driven ALU vectors (R4, R5)
    for (int v = 0; v < NVEC; v++) begin
      clear_mem();
      mem[0] = enc_i(O_ADDI, 0, 1, VEC[v].a);
      mem[1] = enc_i(O_ADDI, 0, 2, VEC[v].b);
      case (VEC[v].kind)
        2'd0:    mem[2] = enc_r(VEC[v].op, 1, 2, 3);
        2'd1:    mem[2] = enc_i(VEC[v].op, 1, 3, VEC[v].b);
        default: mem[2] = enc_r(O_MOV, 1, 3, 0);
      endcase
      mem[3] = enc_i(O_SW, 0, 3, 16'h8000);
      mem[4] = enc_j(O_HLT, 0);
      run_prog(VEC[v].kind == 2'd1 ? "R5" : "R4");
      check(VEC[v].kind == 2'd1 ? "R5 immediate result" : "R4 register result",
            st_log[0], VEC[v].exp);
    end

    // R1: registers cleared by reset, first fetch from 0; R2/R9 timing
    clear_mem();
    mem[0] = enc_i(O_SW, 0, 3, 16'h8000);
    mem[1] = enc_i(O_ADDI, 0, 1, 16'd1);
    mem[2] = enc_i(O_ADDI, 1, 1, 16'd1);
    mem[3] = enc_i(O_SW, 0, 1, 16'h8000);
    mem[4] = enc_j(O_HLT, 0);
    run_prog("R1");
    check("R1 register cleared after reset", st_log[0], 0);
    check("R1 first fetch at address 0", {31'd0, fetch_t[0] >= 0}, 1);
    check("R2 immediate op fetch spacing", fetch_t[3] - fetch_t[2], 3);
    check("R9 store fetch spacing", fetch_t[1] - fetch_t[0], 4);
    check("R2 chained result", st_log[1], 2);

    // R3: writes to register 0 dropped
    clear_mem();
    mem[0] = enc_i(O_ADDI, 0, 0, 16'h0055);
    mem[1] = enc_r(O_ADD, 0, 0, 0);
    mem[2] = enc_r(O_ADD, 0, 0, 4);
    mem[3] = enc_i(O_SW, 0, 0, 16'h8000);
    mem[4] = enc_i(O_SW, 0, 4, 16'h8000);
    mem[5] = enc_j(O_HLT, 0);
    run_prog("R3");
    check("R3 register 0 reads zero", st_log[0], 0);
    check("R3 register 0 as source", st_log[1], 0);

    // R6: branches taken and not taken
    branch_case(O_BEQ, 16'd1, 32'h66);
    branch_case(O_BEQ, 16'd2, 32'h0);
    branch_case(O_BNE, 16'd2, 32'h66);
    branch_case(O_BNE, 16'd1, 32'h0);

    // R7: jump
    clear_mem();
    mem[0] = enc_j(O_JMP, 26'd5);
    mem[1] = enc_i(O_ADDI, 0, 3, 16'd1);
    mem[2] = enc_i(O_SW, 0, 3, 16'h8000);
    mem[3] = enc_j(O_HLT, 0);
    mem[5] = enc_i(O_ADDI, 0, 3, 16'h0077);
    mem[6] = enc_i(O_SW, 0, 3, 16'h8000);
    mem[7] = enc_j(O_HLT, 0);
    run_prog("R7");
    check("R7 jump target reached", st_log[0], 32'h77);
    check("R7 skipped code", {31'd0, fetch_t[1] == -1}, 1);

    // R8/R9: loads, memory store, load-use on the following instruction
    clear_mem();
    mem[20] = 32'hDEAD_BEEF;
    mem[0] = enc_i(O_LW, 0, 4, 16'd20);
    mem[1] = enc_i(O_SW, 0, 4, 16'h8000);
    mem[2] = enc_i(O_LW, 0, 5, 16'h8000);
    mem[3] = enc_i(O_SW, 0, 5, 16'h8000);
    mem[4] = enc_i(O_ADDI, 0, 6, 16'd10);
    mem[5] = enc_i(O_SW, 6, 4, 16'd20);
    mem[6] = enc_j(O_HLT, 0);
    run_prog("R8");
    check("R8 load from memory", st_log[0], 32'hDEAD_BEEF);
    check("R8 load from I/O", st_log[1], IO_IN);
    check("R8 load fetch spacing", fetch_t[1] - fetch_t[0], 4);
    check("R9 store to base+imm", mem[30], 32'hDEAD_BEEF);
    check("R9 enable follows write strobe", oe_bad, 0);

    // R11: undefined opcode as no-operation
    clear_mem();
    mem[0] = 32'hF8A5_5A5A;
    mem[1] = enc_i(O_ADDI, 0, 3, 16'h0011);
    mem[2] = enc_i(O_SW, 0, 3, 16'h8000);
    mem[3] = enc_j(O_HLT, 0);
    run_prog("R11");
    check("R11 undefined opcode skipped", st_log[0], 32'h11);
    check("R11 undefined opcode spacing", fetch_t[1] - fetch_t[0], 3);

    // R10: halt stays, no more bus activity
    clear_mem();
    mem[0] = enc_j(O_HLT, 0);
    mem[1] = enc_i(O_SW, 0, 0, 16'h8000);
    run_prog("R10");
    begin
      int rd0;
      rd0 = rd_cnt;
      repeat (20) @(negedge clk);
      check("R10 halt flag held", {31'd0, halt_n}, 0);
      check("R10 no reads after halt", rd_cnt - rd0, 0);
      check("R10 no stores after halt", st_cnt, 0);
    end

    check("R12 strobes never both low", dual_cnt, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3ms;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule